// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches virtual-to-physical page mappings for 32-bit addresses with 4 KB pages. Each lookup presents a virtual address, the current process tag, the access kind (read or write) and the privilege level. The page number and the tag are compared against every occupied slot at once, and the block answers in the same cycle with one outcome: a translated physical address, a miss, a page fault (the mapping exists but its page is marked not present) or a protection fault (the privilege level lacks the rights for that access kind).

A refill port writes a mapping that was produced elsewhere. It first reuses a slot that already holds the same page and tag, then the lowest free slot, and only when every slot is occupied a tree pseudo-LRU victim. Maintenance commands drop one mapping, drop all mappings of one process, or empty the whole buffer. A read port shows any slot, including the reference and modify bits that hits keep up to date.

Top module: `tlb_fa`

## Requirements
- R1: On a hit, `lk_paddr` equals the slot's physical page number followed by `lk_vaddr[11:0]`, and `lk_cacheable` shows the slot's cacheable bit; both are zero when there is no hit.
- R2: A slot matches only when it is occupied and both its page number (`lk_vaddr[31:12]`) and its process tag equal the request; with no matching slot and `lk_valid` high, `lk_miss` is raised. At most one slot ever matches.
- R3: A matching slot whose present bit is 0 raises `lk_page_fault` and gives no translation.
- R4: Rights are two bits per privilege level: 00 no access, 01 read only, 10 or 11 read and write. `lk_kernel` high selects the kernel rights, otherwise the user rights. A present match whose rights forbid the access raises `lk_prot_fault`. At most one of hit, miss, page fault and protection fault is high, and none when `lk_valid` is low.
- R5: A hit sets the slot's reference bit on the next edge; a write hit also sets its modify bit. Faults and misses change neither. A refill clears both bits of the slot it writes.
- R6: A refill writes the slot already holding the same page and tag; failing that, the lowest-index unoccupied slot; failing that, the pseudo-LRU victim.
- R7: Replacement state is a 15-node binary tree in heap order (node n has children 2n+1 and 2n+2, index bits taken MSB first). A node value of 0 points left, 1 right. Touching a slot sets each node on its path to point away from it; the victim is found by following the pointers from the root. A refill touches its slot; otherwise a hit touches its slot.
- R8: A single-entry invalidate frees only the slot holding the given page and tag.
- R9: A per-process flush frees every slot whose tag equals the given tag and no other.
- R10: A flush-all frees every slot.
- R11: Commands are applied at the clock edge with priority flush-all, per-process flush, invalidate, refill; a lower command in the same cycle is dropped. Lookup outputs reflect the state before that edge.
- R12: After reset every slot is unoccupied, so every lookup misses, and the replacement tree is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_kernel | input | 1 | Access is at kernel privilege |
| cur_pid | input | 8 | Process tag of the requester |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching slot |
| lk_page_fault | output | 1 | Match with page not present |
| lk_prot_fault | output | 1 | Match with insufficient rights |
| lk_paddr | output | 32 | Translated physical address |
| lk_cacheable | output | 1 | Cacheable bit of the hit slot |
| fill_valid | input | 1 | Refill command |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_pid | input | 8 | Refill process tag |
| fill_ppn | input | 20 | Refill physical page number |
| fill_present | input | 1 | Refill page present bit |
| fill_krights | input | 2 | Refill kernel rights |
| fill_urights | input | 2 | Refill user rights |
| fill_cacheable | input | 1 | Refill cacheable bit |
| inv_valid | input | 1 | Single-entry invalidate command |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_pid | input | 8 | Process tag to invalidate |
| flush_pid_valid | input | 1 | Per-process flush command |
| flush_pid | input | 8 | Process tag to flush |
| flush_all | input | 1 | Flush every slot |
| rd_index | input | 4 | Slot shown on the read port |
| rd_used | output | 1 | Slot is occupied |
| rd_vpn | output | 20 | Slot virtual page number |
| rd_pid | output | 8 | Slot process tag |
| rd_ppn | output | 20 | Slot physical page number |
| rd_present | output | 1 | Slot page present bit |
| rd_ref | output | 1 | Slot reference bit |
| rd_mod | output | 1 | Slot modify bit |

## Verification
A corrupted occupancy bit or tag shows on the very next lookup of that page as a wrong miss or a stale hit, and on the read port at once. A wrong replacement tree bit is silent until the buffer is full; it then shows as a refill landing in an unexpected slot, so the bench fills the buffer completely and compares every slot after refills. Reference and modify errors appear on the read port one edge after the hit that should have set them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // Access rights per privilege level
   typedef logic [1:0] rights_t;
   localparam rights_t RIGHTS_NONE = 2'b00;
   localparam rights_t RIGHTS_READ = 2'b01;
   localparam rights_t RIGHTS_RW   = 2'b10;

   // Write needs bit 1; read needs any non-zero code
   function automatic logic rights_allow(rights_t r, logic wr);
      return wr ? r[1] : (r != RIGHTS_NONE);
   endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N     = 16,
   parameter int VPN_W = 20,
   parameter int PID_W = 8
) (
   input  logic [N-1:0]     used,
   input  logic [VPN_W-1:0] vpn [N],
   input  logic [PID_W-1:0] pid [N],
   input  logic [VPN_W-1:0] key_vpn,
   input  logic [PID_W-1:0] key_pid,
   output logic [N-1:0]     match
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = used[g] && (vpn[g] == key_vpn) && (pid[g] == key_pid);
   end
endmodule

// File: rtl/tlb_prienc.sv
module tlb_prienc #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             found
);
   always_comb begin
      idx   = '0;
      found = |req;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
   parameter int WAYS = 16,
   localparam int LVL   = $clog2(WAYS),
   localparam int NODES = WAYS - 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           touch_valid,
   input  logic [LVL-1:0] touch_idx,
   output logic [LVL-1:0] victim
);
   if (WAYS < 2 || (1 << LVL) != WAYS) begin : g_bad_ways
      $error("tlb_plru: WAYS must be a power of two of at least 2");
   end

   logic [NODES-1:0] tree_q, tree_nx;

   always_comb begin
      int node;
      tree_nx = tree_q;
      node    = 0;
      if (touch_valid) begin
         for (int l = 0; l < LVL; l++) begin
            tree_nx[node] = ~touch_idx[LVL-1-l];
            node = 2 * node + 1 + int'(touch_idx[LVL-1-l]);
         end
      end
   end

   always_comb begin
      int node;
      victim = '0;
      node   = 0;
      for (int l = 0; l < LVL; l++) begin
         victim[LVL-1-l] = tree_q[node];
         node = 2 * node + 1 + int'(tree_q[node]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tree_q <= '0;
      else        tree_q <= tree_nx;
   end

   // R7
   plru_avoids_touched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_valid |=> victim != $past(touch_idx));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_pkg::*;
#(
   parameter int ENTRIES   = 16,
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PID_W     = 8,
   localparam int VPN_W = VA_W - PAGE_BITS,
   localparam int PPN_W = PA_W - PAGE_BITS,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   input  logic             lk_kernel,
   input  logic [PID_W-1:0] cur_pid,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_page_fault,
   output logic             lk_prot_fault,
   output logic [PA_W-1:0]  lk_paddr,
   output logic             lk_cacheable,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PID_W-1:0] fill_pid,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_present,
   input  logic [1:0]       fill_krights,
   input  logic [1:0]       fill_urights,
   input  logic             fill_cacheable,
   input  logic             inv_valid,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic [PID_W-1:0] inv_pid,
   input  logic             flush_pid_valid,
   input  logic [PID_W-1:0] flush_pid,
   input  logic             flush_all,
   input  logic [IDX_W-1:0] rd_index,
   output logic             rd_used,
   output logic [VPN_W-1:0] rd_vpn,
   output logic [PID_W-1:0] rd_pid,
   output logic [PPN_W-1:0] rd_ppn,
   output logic             rd_present,
   output logic             rd_ref,
   output logic             rd_mod
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("tlb_fa: ENTRIES must be a power of two of at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("tlb_fa: PAGE_BITS must be below both address widths");
   end

   // Slot storage
   logic [ENTRIES-1:0] used_q, pres_q, ref_q, mod_q, cach_q;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PID_W-1:0]   pid_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   rights_t            kr_q  [ENTRIES];
   rights_t            ur_q  [ENTRIES];

   // Parallel comparators: lookup, refill, invalidate
   logic [ENTRIES-1:0] lk_match, fl_match, iv_match;

   tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
      .used(used_q), .vpn(vpn_q), .pid(pid_q),
      .key_vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .key_pid(cur_pid), .match(lk_match));
   tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fl (
      .used(used_q), .vpn(vpn_q), .pid(pid_q),
      .key_vpn(fill_vpn), .key_pid(fill_pid), .match(fl_match));
   tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_iv (
      .used(used_q), .vpn(vpn_q), .pid(pid_q),
      .key_vpn(inv_vpn), .key_pid(inv_pid), .match(iv_match));

   logic [IDX_W-1:0] lk_idx, flm_idx, free_idx, victim, fill_idx, touch_idx;
   logic             lk_found, flm_found, free_found;

   tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_lk (
      .req(lk_match), .idx(lk_idx), .found(lk_found));
   tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_fl (
      .req(fl_match), .idx(flm_idx), .found(flm_found));
   tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_free (
      .req(~used_q), .idx(free_idx), .found(free_found));

   // Lookup outcome
   logic    lk_any, lk_allow;
   rights_t lk_rights;

   always_comb begin
      lk_any        = lk_valid && lk_found;
      lk_rights     = lk_kernel ? kr_q[lk_idx] : ur_q[lk_idx];
      lk_allow      = rights_allow(lk_rights, lk_write);
      lk_miss       = lk_valid && !lk_found;
      lk_page_fault = lk_any && !pres_q[lk_idx];
      lk_prot_fault = lk_any && pres_q[lk_idx] && !lk_allow;
      lk_hit        = lk_any && pres_q[lk_idx] && lk_allow;
      lk_paddr      = lk_hit ? {ppn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;
      lk_cacheable  = lk_hit && cach_q[lk_idx];
   end

   // Refill placement and replacement tree
   logic fill_do, touch_valid;

   assign fill_do     = fill_valid && !flush_all && !flush_pid_valid && !inv_valid;
   assign fill_idx    = flm_found ? flm_idx : (free_found ? free_idx : victim);
   assign touch_valid = fill_do || lk_hit;
   assign touch_idx   = fill_do ? fill_idx : lk_idx;

   tlb_plru #(.WAYS(ENTRIES)) u_plru (
      .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
      .touch_idx(touch_idx), .victim(victim));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
         pres_q <= '0;
         ref_q  <= '0;
         mod_q  <= '0;
         cach_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i] <= '0;
            pid_q[i] <= '0;
            ppn_q[i] <= '0;
            kr_q[i]  <= RIGHTS_NONE;
            ur_q[i]  <= RIGHTS_NONE;
         end
      end else begin
         if (lk_hit) begin
            ref_q[lk_idx] <= 1'b1;
            if (lk_write) mod_q[lk_idx] <= 1'b1;
         end
         if (flush_all) begin
            used_q <= '0;
         end else if (flush_pid_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (pid_q[i] == flush_pid) used_q[i] <= 1'b0;
            end
         end else if (inv_valid) begin
            used_q <= used_q & ~iv_match;
         end else if (fill_do) begin
            used_q[fill_idx] <= 1'b1;
            pres_q[fill_idx] <= fill_present;
            ref_q[fill_idx]  <= 1'b0;
            mod_q[fill_idx]  <= 1'b0;
            cach_q[fill_idx] <= fill_cacheable;
            vpn_q[fill_idx]  <= fill_vpn;
            pid_q[fill_idx]  <= fill_pid;
            ppn_q[fill_idx]  <= fill_ppn;
            kr_q[fill_idx]   <= fill_krights;
            ur_q[fill_idx]   <= fill_urights;
         end
      end
   end

   // Read port
   assign rd_used    = used_q[rd_index];
   assign rd_vpn     = vpn_q[rd_index];
   assign rd_pid     = pid_q[rd_index];
   assign rd_ppn     = ppn_q[rd_index];
   assign rd_present = pres_q[rd_index];
   assign rd_ref     = ref_q[rd_index];
   assign rd_mod     = mod_q[rd_index];

   // R4
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_hit, lk_miss, lk_page_fault, lk_prot_fault}));
   // R4
   outcome_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit || lk_miss || lk_page_fault || lk_prot_fault) |-> lk_valid);
   // R2
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R5
   write_hit_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write && !fill_do) |=> mod_q[$past(lk_idx)]);
   // R6
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_do |=> used_q[$past(fill_idx)]);
   // R10
   flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (used_q == '0));
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid, lk_write, lk_kernel;
   logic [31:0] lk_vaddr;
   logic [7:0]  cur_pid;
   logic        lk_hit, lk_miss, lk_page_fault, lk_prot_fault, lk_cacheable;
   logic [31:0] lk_paddr;
   logic        fill_valid, fill_present, fill_cacheable;
   logic [19:0] fill_vpn, fill_ppn;
   logic [7:0]  fill_pid;
   logic [1:0]  fill_krights, fill_urights;
   logic        inv_valid;
   logic [19:0] inv_vpn;
   logic [7:0]  inv_pid;
   logic        flush_pid_valid;
   logic [7:0]  flush_pid;
   logic        flush_all;
   logic [3:0]  rd_index;
   logic        rd_used, rd_present, rd_ref, rd_mod;
   logic [19:0] rd_vpn, rd_ppn;
   logic [7:0]  rd_pid;

   tlb_fa dut (.*);

   always #5 clk = ~clk;

   int tests = 0;
   int fails = 0;

   // Reference model
   bit        m_used[N], m_pres[N], m_ref[N], m_mod[N], m_cach[N];
   bit [19:0] m_vpn[N], m_ppn[N];
   bit [7:0]  m_pid[N];
   bit [1:0]  m_kr[N], m_ur[N];
   bit [14:0] m_tree;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int m_victim();
      int node = 0;
      int v = 0;
      for (int l = 0; l < 4; l++) begin
         v = v * 2 + int'(m_tree[node]);
         node = 2 * node + 1 + int'(m_tree[node]);
      end
      return v;
   endfunction

   function automatic void m_touch(int w);
      int node = 0;
      for (int l = 0; l < 4; l++) begin
         bit b = bit'((w >> (3 - l)) & 1);
         m_tree[node] = ~b;
         node = 2 * node + 1 + int'(b);
      end
   endfunction

   function automatic int m_find(bit [19:0] v, bit [7:0] p);
      for (int i = 0; i < N; i++)
         if (m_used[i] && m_vpn[i] == v && m_pid[i] == p) return i;
      return -1;
   endfunction

   function automatic int m_fill_slot();
      int f = m_find(fill_vpn, fill_pid);
      if (f >= 0) return f;
      for (int i = 0; i < N; i++) if (!m_used[i]) return i;
      return m_victim();
   endfunction

   task automatic idle();
      lk_valid = 0; lk_write = 0; lk_kernel = 0; lk_vaddr = '0; cur_pid = '0;
      fill_valid = 0; fill_present = 0; fill_cacheable = 0; fill_vpn = '0;
      fill_ppn = '0; fill_pid = '0; fill_krights = '0; fill_urights = '0;
      inv_valid = 0; inv_vpn = '0; inv_pid = '0;
      flush_pid_valid = 0; flush_pid = '0; flush_all = 0; rd_index = '0;
   endtask

   // Check the lookup now, advance the model, move to the next falling edge
   task automatic cycle();
      int  idx;
      int  fi;
      bit  eh, em, ep, ex, fill_do;
      bit [1:0] r;
      string tag;
      #1;
      idx = m_find(lk_vaddr[31:12], cur_pid);
      eh = 0; em = 0; ep = 0; ex = 0;
      if (lk_valid) begin
         if (idx < 0) em = 1;
         else if (!m_pres[idx]) ep = 1;
         else begin
            r = lk_kernel ? m_kr[idx] : m_ur[idx];
            if (lk_write ? r[1] : (r != 2'b00)) eh = 1; else ex = 1;
         end
      end
      tag = ep ? "R3" : ex ? "R4" : eh ? "R1" : "R2";
      chk(tag, "outcome {hit,miss,pf,prot}",
          {28'd0, lk_hit, lk_miss, lk_page_fault, lk_prot_fault},
          {28'd0, eh, em, ep, ex});
      if (eh) begin
         chk("R1", "paddr", lk_paddr, {m_ppn[idx], lk_vaddr[11:0]});
         chk("R1", "cacheable", {31'd0, lk_cacheable}, {31'd0, m_cach[idx]});
      end else begin
         chk("R1", "paddr without hit", lk_paddr, 32'd0);
      end
      fill_do = fill_valid && !flush_all && !flush_pid_valid && !inv_valid;
      fi = fill_do ? m_fill_slot() : 0;
      if (eh) begin
         m_ref[idx] = 1;
         if (lk_write) m_mod[idx] = 1;
      end
      if (fill_do) m_touch(fi);
      else if (eh) m_touch(idx);
      if (flush_all) begin
         for (int i = 0; i < N; i++) m_used[i] = 0;
      end else if (flush_pid_valid) begin
         for (int i = 0; i < N; i++) if (m_pid[i] == flush_pid) m_used[i] = 0;
      end else if (inv_valid) begin
         int k = m_find(inv_vpn, inv_pid);
         if (k >= 0) m_used[k] = 0;
      end else if (fill_do) begin
         m_used[fi] = 1; m_pres[fi] = fill_present; m_ref[fi] = 0; m_mod[fi] = 0;
         m_cach[fi] = fill_cacheable; m_vpn[fi] = fill_vpn; m_pid[fi] = fill_pid;
         m_ppn[fi] = fill_ppn; m_kr[fi] = fill_krights; m_ur[fi] = fill_urights;
      end
      @(negedge clk);
      idle();
   endtask

   // Compare every slot on the read port (inputs idle, so edges change nothing)
   task automatic sweep(string tag);
      for (int i = 0; i < N; i++) begin
         rd_index = 4'(i);
         #1;
         chk(tag, $sformatf("slot %0d used", i), {31'd0, rd_used}, {31'd0, m_used[i]});
         if (m_used[i]) begin
            chk(tag, $sformatf("slot %0d vpn", i), {12'd0, rd_vpn}, {12'd0, m_vpn[i]});
            chk(tag, $sformatf("slot %0d pid", i), {24'd0, rd_pid}, {24'd0, m_pid[i]});
            chk(tag, $sformatf("slot %0d ppn", i), {12'd0, rd_ppn}, {12'd0, m_ppn[i]});
            chk(tag, $sformatf("slot %0d present", i), {31'd0, rd_present}, {31'd0, m_pres[i]});
            chk("R5", $sformatf("slot %0d ref", i), {31'd0, rd_ref}, {31'd0, m_ref[i]});
            chk("R5", $sformatf("slot %0d mod", i), {31'd0, rd_mod}, {31'd0, m_mod[i]});
         end
      end
      @(negedge clk);
      idle();
   endtask

   task automatic do_fill(bit [19:0] v, bit [7:0] p, bit [19:0] pp, bit pres,
                          bit [1:0] kr, bit [1:0] ur, bit c);
      fill_valid = 1; fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_present = pres;
      fill_krights = kr; fill_urights = ur; fill_cacheable = c;
      cycle();
   endtask

   task automatic do_look(bit [19:0] v, bit [7:0] p, bit [11:0] off, bit wr, bit kern);
      lk_valid = 1; lk_vaddr = {v, off}; cur_pid = p; lk_write = wr; lk_kernel = kern;
      cycle();
   endtask

   bit done = 0;

   initial begin
      #2_000_000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int v;
      void'($urandom(32'd20240611));
      idle();
      m_tree = '0;
      for (int i = 0; i < N; i++) begin
         m_used[i] = 0; m_pres[i] = 0; m_ref[i] = 0; m_mod[i] = 0; m_cach[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R12: empty after reset
      sweep("R12");
      do_look(20'h00005, 8'd1, 12'h123, 0, 0);

      // R1 / R4: basic translation and rights
      do_fill(20'h00005, 8'd1, 20'hABCDE, 1, 2'b10, 2'b01, 1);
      do_look(20'h00005, 8'd1, 12'h123, 0, 0);
      #1 chk("R1", "directed paddr", lk_paddr, 32'd0);
      do_look(20'h00005, 8'd1, 12'h7FF, 1, 0);
      do_look(20'h00005, 8'd1, 12'h7FF, 1, 1);
      do_look(20'h00005, 8'd2, 12'h000, 0, 0);
      // R3: page not present
      do_fill(20'h00009, 8'd1, 20'h11111, 0, 2'b10, 2'b10, 0);
      do_look(20'h00009, 8'd1, 12'h010, 0, 1);
      // R4: no-access user rights, write-allowed code 11
      do_fill(20'h0000A, 8'd1, 20'h22222, 1, 2'b11, 2'b00, 0);
      do_look(20'h0000A, 8'd1, 12'h004, 0, 0);
      do_look(20'h0000A, 8'd1, 12'h004, 1, 1);
      sweep("R5");

      // R6: refill of an existing page overwrites the same slot
      do_fill(20'h00005, 8'd1, 20'h33333, 1, 2'b10, 2'b10, 0);
      sweep("R6");

      // R7: fill completely then evict
      flush_all = 1; cycle();
      for (int i = 0; i < N; i++) do_fill(20'd100 + 20'(i), 8'd0, 20'(i), 1, 2'b10, 2'b10, 0);
      do_look(20'd103, 8'd0, 12'h0, 0, 0);
      do_look(20'd110, 8'd0, 12'h0, 1, 0);
      v = m_victim();
      do_fill(20'd200, 8'd0, 20'hFFFFF, 1, 2'b01, 2'b01, 0);
      rd_index = 4'(v);
      #1 chk("R7", "victim slot holds new page", {12'd0, rd_vpn}, 32'd200);
      @(negedge clk); idle();
      sweep("R7");

      // R8: single invalidate
      inv_valid = 1; inv_vpn = 20'd105; inv_pid = 8'd0; cycle();
      sweep("R8");
      do_look(20'd105, 8'd0, 12'h0, 0, 0);
      // R6: hole is reused first
      do_fill(20'd300, 8'd4, 20'h44444, 1, 2'b10, 2'b10, 1);
      sweep("R6");

      // R9: flush one process
      flush_pid_valid = 1; flush_pid = 8'd0; cycle();
      sweep("R9");
      // R11: flush-all beats refill
      flush_all = 1; fill_valid = 1; fill_vpn = 20'd7; fill_pid = 8'd3; cycle();
      sweep("R11");
      // R11: invalidate beats refill
      fill_valid = 1; fill_vpn = 20'd8; fill_pid = 8'd3; inv_valid = 1; inv_vpn = 20'd8; inv_pid = 8'd3;
      cycle();
      sweep("R11");

      // Random phase
      for (int c = 0; c < 4000; c++) begin
         int op = int'($urandom_range(99));
         lk_valid = ($urandom_range(9) < 7);
         lk_vaddr = {20'($urandom_range(23)), 12'($urandom())};
         cur_pid  = 8'($urandom_range(2));
         lk_write = 1'($urandom());
         lk_kernel = 1'($urandom());
         if (op < 30) begin
            fill_valid = 1; fill_vpn = 20'($urandom_range(23)); fill_pid = 8'($urandom_range(2));
            fill_ppn = 20'($urandom()); fill_present = ($urandom_range(9) != 0);
            fill_krights = 2'($urandom()); fill_urights = 2'($urandom());
            fill_cacheable = 1'($urandom());
         end else if (op < 36) begin
            inv_valid = 1; inv_vpn = 20'($urandom_range(23)); inv_pid = 8'($urandom_range(2));
            fill_valid = 1'($urandom()); fill_vpn = 20'($urandom_range(23));
         end else if (op < 38) begin
            flush_pid_valid = 1; flush_pid = 8'($urandom_range(2));
         end else if (op < 39) begin
            flush_all = 1;
         end
         cycle();
         if (c % 250 == 249) sweep("R6");
      end
      sweep("R10");
      flush_all = 1; cycle();
      sweep("R10");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule